// File: doc/BRIEF.md
# Dual-Clock FIFO with Handshaked Pointer Transfer

This block is a first-in first-out buffer between two clock domains whose clocks have no phase or frequency relationship. The write side stores words under its own clock and the read side removes them under another. Each side keeps binary pointers. Each side also keeps a delayed local copy of the other side's pointer, and it computes its own flag (full on the write side, empty on the read side) from that copy.

Pointers do not cross domains in Gray code. Each crossing is a four-phase request/acknowledge exchange. The sender parks its pointer in a holding register and raises a request. The receiver sees the request after a two-flop synchroniser, captures the parked value and raises an acknowledge. The acknowledge returns through a second two-flop synchroniser. Both lines then fall in turn, and only after that does the sender park a fresh pointer. Because the held value cannot change while it is being captured, every bit reaches the other side coherent. The cost is that the copy lags, so a flag may stay set longer than needed but never clears too soon.

Each domain has its own synchronous active-low reset. The two resets are expected to be applied together. Read data shows the oldest stored word whenever `empty` is low, and a read pulse moves on to the next word.

Top module: `hp_async_fifo`

## Requirements
- R1: After reset, `empty` is 1 and `full` is 0.
- R2: Words leave on `rd_data` in the order they were accepted on `wr_data`, for any interleaving of writes and reads.
- R3: After 16 accepted writes with no reads, `full` is 1, and the write side never accounts more than 16 words ahead of its copy of the read pointer.
- R4: A write while `full` is 1 is ignored: nothing is stored and the write pointer keeps its value.
- R5: A read while `empty` is 1 is ignored: the read pointer keeps its value and the read side never sees more words consumed than written.
- R6: The flags are conservative. `empty` is still 1 just after the write edge that fills an empty buffer, and `full` is still 1 just after the read edge that frees a slot in a full buffer.
- R7: Once the opposite side has moved, a set flag clears within 40 cycles of its own domain's clock.
- R8: The parked pointer stays stable while its request is raised, and a received pointer copy only moves forward, by at most the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain synchronous reset, active low |
| wr_en | input | 1 | Write request; accepted when `full` is 0 |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free slot as seen by the write side |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain synchronous reset, active low |
| rd_en | input | 1 | Read request; accepted when `empty` is 0 |
| rd_data | output | DATA_W | Oldest stored word, valid while `empty` is 0 |
| empty | output | 1 | No word available as seen by the read side |

## Verification
If a pointer copy is corrupted or handed over early, words show up at `rd_data` out of order or duplicated, or `empty` drops with no word behind it. These faults surface at the first read after the bad transfer. A handshake that stalls leaves a flag stuck, so the bench bounds how long each flag may take to clear. A pointer that advances on an ignored request leaves one word too many or too few, and this is exposed when a full buffer is drained to empty.

// File: rtl/hpf_pkg.sv
// Shared types for the handshake-pointer FIFO.
package hpf_pkg;
    // Sender phases of the four-phase pointer transfer.
    typedef enum logic [1:0] {
        TX_LOAD    = 2'd0,
        TX_WAIT_HI = 2'd1,
        TX_WAIT_LO = 2'd2
    } tx_state_e;
endpackage

// File: rtl/hpf_sync.sv
// Multi-flop level synchroniser.
// Assumes: d is a slow level held for several destination cycles; STAGES >= 2.
module hpf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hpf_ptr_link.sv
// Carries a binary pointer from a source clock domain to a destination domain
// with a four-phase req/ack exchange. The held value is frozen for the whole
// exchange, so the destination always captures a coherent word.
// Assumes: both resets are applied together; the source pointer advances by at
// most DEPTH between two completed exchanges.
module hpf_ptr_link
    import hpf_pkg::*;
#(
    parameter int PW     = 5,
    parameter int STAGES = 2,
    parameter int DEPTH  = 16
) (
    input  logic          src_clk,
    input  logic          src_rst_n,
    input  logic [PW-1:0] src_ptr,
    input  logic          dst_clk,
    input  logic          dst_rst_n,
    output logic [PW-1:0] dst_ptr
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    tx_state_e     st;
    logic [PW-1:0] hold;
    logic          req, req_s;
    logic          ack, ack_s;

    // Source side: park the pointer, raise req, then follow ack through both phases.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) begin
            st   <= TX_LOAD;
            hold <= '0;
            req  <= 1'b0;
        end else begin
            case (st)
                TX_LOAD: begin
                    hold <= src_ptr;
                    req  <= 1'b1;
                    st   <= TX_WAIT_HI;
                end
                TX_WAIT_HI: if (ack_s) begin
                    req <= 1'b0;
                    st  <= TX_WAIT_LO;
                end
                TX_WAIT_LO: if (!ack_s) st <= TX_LOAD;
                default: st <= TX_LOAD;
            endcase
        end
    end

    hpf_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk(src_clk), .rst_n(src_rst_n), .d(ack), .q(ack_s)
    );

    hpf_sync #(.STAGES(STAGES)) u_req_sync (
        .clk(dst_clk), .rst_n(dst_rst_n), .d(req), .q(req_s)
    );

    // Destination side: capture on req high, release ack once req is seen low.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            dst_ptr <= '0;
            ack     <= 1'b0;
        end else if (req_s && !ack) begin
            dst_ptr <= hold;
            ack     <= 1'b1;
        end else if (!req_s && ack) begin
            ack <= 1'b0;
        end
    end

    // R8
    hold_stable_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (req && $past(req)) |-> $stable(hold));

    // R8
    copy_advance_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        (PW'(dst_ptr - $past(dst_ptr)) <= DEPTH_P));
endmodule

// File: rtl/hp_async_fifo.sv
// Dual-clock FIFO. Each domain owns its pointer, address and flag logic and
// receives the other side's pointer through an hpf_ptr_link. Stale copies can
// only make full or empty appear early.
// Assumes: unrelated clocks; wr_rst_n and rd_rst_n are asserted together.
module hp_async_fifo #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty
);
    localparam int            DEPTH   = 1 << ADDR_W;
    localparam int            PW      = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wptr, rptr;
    logic [PW-1:0]     rptr_at_wr, wptr_at_rd;
    logic              wr_ok, rd_ok;

    // ---------------- write domain ----------------
    assign full  = (wptr[ADDR_W] != rptr_at_wr[ADDR_W]) &&
                   (wptr[ADDR_W-1:0] == rptr_at_wr[ADDR_W-1:0]);
    assign wr_ok = wr_en && !full;

    // Advance the write pointer on an accepted write.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n)  wptr <= '0;
        else if (wr_ok) wptr <= wptr + 1'b1;
    end

    // Store the accepted word at the write address.
    always_ff @(posedge wr_clk) begin
        if (wr_ok) mem[wptr[ADDR_W-1:0]] <= wr_data;
    end

    // R3
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (PW'(wptr - rptr_at_wr) <= DEPTH_P));

    // ---------------- read domain ----------------
    assign empty   = (rptr == wptr_at_rd);
    assign rd_ok   = rd_en && !empty;
    assign rd_data = mem[rptr[ADDR_W-1:0]];

    // Advance the read pointer on an accepted read.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n)  rptr <= '0;
        else if (rd_ok) rptr <= rptr + 1'b1;
    end

    // R5
    no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (PW'(wptr_at_rd - rptr) <= DEPTH_P));

    // ---------------- pointer crossings ----------------
    hpf_ptr_link #(.PW(PW), .STAGES(SYNC_STAGES), .DEPTH(DEPTH)) u_w2r (
        .src_clk(wr_clk), .src_rst_n(wr_rst_n), .src_ptr(wptr),
        .dst_clk(rd_clk), .dst_rst_n(rd_rst_n), .dst_ptr(wptr_at_rd)
    );

    hpf_ptr_link #(.PW(PW), .STAGES(SYNC_STAGES), .DEPTH(DEPTH)) u_r2w (
        .src_clk(rd_clk), .src_rst_n(rd_rst_n), .src_ptr(rptr),
        .dst_clk(wr_clk), .dst_rst_n(wr_rst_n), .dst_ptr(rptr_at_wr)
    );
endmodule

// File: tb/test_hp_async_fifo.sv
module test_hp_async_fifo;
    localparam int DW = 8;
    localparam int LIM = 40;

    logic wr_clk = 0, rd_clk = 0;
    logic wr_rst_n = 0, rd_rst_n = 0;
    logic wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic full, empty;
    int tests = 0, fails = 0;

    always #10 wr_clk = ~wr_clk;   // 50 MHz write clock
    always #13 rd_clk = ~rd_clk;   // unrelated read clock

    hp_async_fifo i_hp_async_fifo (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data), .empty(empty)
    );

    // Vector: {op, data}; op 0 = write data, op 1 = read and expect data.
    localparam logic [8:0] VEC [12] = '{
        {1'b0, 8'hA1}, {1'b0, 8'hB2}, {1'b1, 8'hA1}, {1'b0, 8'hC3},
        {1'b1, 8'hB2}, {1'b1, 8'hC3}, {1'b0, 8'h04}, {1'b0, 8'hF5},
        {1'b0, 8'h66}, {1'b1, 8'h04}, {1'b1, 8'hF5}, {1'b1, 8'h66}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge wr_clk); wr_en = 1; wr_data = d;
        @(negedge wr_clk); wr_en = 0;
    endtask

    task automatic wait_empty(input logic val, output int n);
        n = 0;
        while (empty !== val && n < 100) begin @(negedge rd_clk); n++; end
    endtask

    task automatic pop(input logic [DW-1:0] exp, input string tag);
        int n;
        @(negedge rd_clk);
        wait_empty(1'b0, n);
        chk(!empty && rd_data == exp, tag, int'(rd_data), int'(exp));
        rd_en = 1;
        @(negedge rd_clk); rd_en = 0;
    endtask

    initial begin
        #4_000_000;
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (4) @(negedge wr_clk);
        wr_rst_n = 1; rd_rst_n = 1;
        @(negedge rd_clk);
        chk(empty == 1, "R1 empty after reset", empty, 1);
        @(negedge wr_clk);
        chk(full == 0, "R1 full after reset", full, 0);

        // R2 ordering table (pointer copies consistent, R8)
        foreach (VEC[i]) begin
            if (VEC[i][8] == 1'b0) push(VEC[i][7:0]);
            else pop(VEC[i][7:0], "R2 order");
        end

        // R5 reads on empty ignored
        repeat (LIM) @(negedge rd_clk);
        chk(empty == 1, "R5 settled empty", empty, 1);
        @(negedge rd_clk); rd_en = 1;
        repeat (3) @(negedge rd_clk);
        rd_en = 0;
        repeat (LIM) @(negedge rd_clk);
        chk(empty == 1, "R5 empty after reads on empty", empty, 1);

        // R6 early empty, R7 bounded release
        @(negedge wr_clk); wr_en = 1; wr_data = 8'h5A;
        @(posedge wr_clk); #1;
        chk(empty == 1, "R6 empty held after write", empty, 1);
        @(negedge wr_clk); wr_en = 0;
        wait_empty(1'b0, n);
        chk(n < LIM, "R7 empty release cycles", n, LIM);
        pop(8'h5A, "R5 data after ignored reads");
        repeat (LIM) @(negedge wr_clk);

        // R3 fill to full
        for (int k = 0; k < 16; k++) push(8'h10 + 8'(k));
        @(negedge wr_clk);
        chk(full == 1, "R3 full after 16 writes", full, 1);

        // R4 writes on full ignored
        for (int k = 0; k < 3; k++) push(8'hEE);
        chk(full == 1, "R4 full stays", full, 1);

        // R6 early full on first read
        @(negedge rd_clk); wait_empty(1'b0, n);
        chk(rd_data == 8'h10, "R4 head data", int'(rd_data), 8'h10);
        rd_en = 1;
        @(posedge rd_clk); #1;
        chk(full == 1, "R6 full held after read", full, 1);
        @(negedge rd_clk); rd_en = 0;
        n = 0;
        while (full !== 0 && n < 100) begin @(negedge wr_clk); n++; end
        chk(n < LIM, "R7 full release cycles", n, LIM);

        for (int k = 1; k < 16; k++) pop(8'h10 + 8'(k), "R4 drain order");
        repeat (LIM) @(negedge rd_clk);
        chk(empty == 1, "R4 no extra word stored", empty, 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule